// File: doc/BRIEF.md
# Byte-Stream Register Bus Slave

This block sits at the far end of a half-duplex link that carries register accesses one byte per clock. A master shifts in a request over a byte lane with a valid strobe. The block decodes the request length from its leading bit and issues a single parallel register-bus access. It then waits for the bus to answer and returns the answer over the same lane once the master hands the lane over.

The master owns a direction line. While that line is low the master drives the lane. While it is high the slave may drive. The slave's drive enable follows the direction line directly, so the master can cut a response short at any time by pulling direction low. The slave then stops driving in that same cycle and forgets the transaction. A short, programmable turnaround gap after direction rises keeps the first response byte from reaching the master before its input pipeline is ready. A bounded wait on the bus side means a missing bus acknowledge still produces a response, with the acknowledge bit clear.

Tri-state pads are outside the block. It provides a separate drive-enable output next to its outgoing valid and data.

Top module: `bytelink_reg_slave`

## Requirements
- R1: Request bytes arrive most significant byte and bit first. Bit 7 of the first byte selects the operation: 1 is a write, 0 is a read. Bits 6:0 of the first byte and all of the second byte form the 15-bit address. A write has four more bytes of write data, MSB first, for 6 bytes in all; a read is 2 bytes. The access is presented with that address and, for writes, that data.
- R2: In the cycle after the final request byte is accepted, exactly one of the write or read strobes is high, for that one cycle only. No strobe is raised while request bytes are still arriving.
- R3: A bus acknowledge counts if it arrives in the strobe cycle or within the following BUS_WAIT-1 cycles. The status and read data of that cycle are captured, and the response acknowledge bit is 1.
- R4: If no acknowledge arrives in that window, the response carries acknowledge bit 0, status 00 and read data 0. A later acknowledge is ignored.
- R5: The status byte is {5'b00000, ack, status[1:0]}. A write response is that single byte. A read response is 5 bytes: the 32-bit read data MSB first, then the status byte.
- R6: Whenever direction is low, the drive enable and outgoing valid are low in that same cycle.
- R7: Direction rises in some cycle, with a response ready. Drive enable and valid then stay low for that cycle and the next TURN_WAIT-1 cycles, and both go high TURN_WAIT cycles after the rise.
- R8: Response bytes go out in consecutive cycles. In the cycle after the last byte, valid and drive enable are low even if direction stays high.
- R9: If direction falls before the last response byte, the response is abandoned. The next byte the master sends is decoded as the first byte of a new request.
- R10: Valid input is ignored while a response is pending and while direction is high. No strobe results, and the pending response is unchanged.
- R11: During and after reset the drive enable, valid output and both strobes are low, and the receiver expects a first request byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_dir_i | input | 1 | Lane direction from the master: 0 master drives, 1 slave may drive |
| link_valid_i | input | 1 | Incoming byte valid |
| link_data_i | input | 8 | Incoming byte |
| link_valid_o | output | 1 | Outgoing byte valid |
| link_data_o | output | 8 | Outgoing byte, zero when not valid |
| link_oe_o | output | 1 | Drive enable for the shared valid and data lines |
| bus_wr_o | output | 1 | Register write strobe, one cycle |
| bus_rd_o | output | 1 | Register read strobe, one cycle |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Register write data |
| bus_ack_i | input | 1 | Register bus acknowledge |
| bus_status_i | input | 2 | Register bus status, taken with the acknowledge |
| bus_rdata_i | input | DATA_W | Register read data, taken with the acknowledge |

## Verification
The assertions assume the master follows the link's rules. It only raises direction after a request is complete, and it does not treat lane contents as a request while direction is high. They also assume the bus answers at most once per strobe. The stimulus keeps to these rules: it drives each request with direction low, and it raises direction only after the bus window has closed. It then deliberately breaks the protocol in two bounded ways. It sends stray bytes while a response is pending, and it sends bytes with direction high, so the ignore rules are exercised without leaving the assumed envelope.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [1:0] {
    BP_IDLE = 2'd0,
    BP_WAIT = 2'd1,
    BP_DONE = 2'd2
  } bp_state_e;

  function automatic logic [7:0] status_byte(input logic ack, input logic [1:0] sts);
    return {5'b00000, ack, sts};
  endfunction

endpackage

// File: rtl/bl_req_rx.sv
module bl_req_rx #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_i,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              release_i,
  output logic              full_o,
  output logic              req_pulse_o,
  output logic              req_wr_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o
);

  localparam int unsigned RD_BYTES = (1 + ADDR_W) / 8;
  localparam int unsigned WR_BYTES = (1 + ADDR_W + DATA_W) / 8;
  localparam int unsigned SR_W     = WR_BYTES * 8;
  localparam int unsigned CNT_W    = $clog2(WR_BYTES + 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_BYTES - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_BYTES - 1);

  logic [SR_W-9:0]   sr_q, sr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cmd_q, cmd_d;
  logic              full_q, full_d;
  logic              pulse_q, pulse_d;
  logic              wro_q, wro_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  logic            accept;
  logic            is_wr_now;
  logic            last;
  logic [SR_W-1:0] sr_nxt;

  assign accept    = valid_i && !dir_i && !full_q;
  assign is_wr_now = (cnt_q == '0) ? data_i[7] : cmd_q;
  assign last      = accept && (cnt_q == (is_wr_now ? WR_LAST : RD_LAST));
  assign sr_nxt    = {sr_q, data_i};

  always_comb begin
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    cmd_d   = cmd_q;
    full_d  = full_q;
    pulse_d = 1'b0;
    wro_d   = wro_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (release_i) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (accept) begin
      sr_d = sr_nxt[SR_W-9:0];
      if (cnt_q == '0) cmd_d = data_i[7];
      if (last) begin
        cnt_d   = '0;
        full_d  = 1'b1;
        pulse_d = 1'b1;
        if (is_wr_now) begin
          wro_d   = sr_nxt[SR_W-1];
          addr_d  = sr_nxt[SR_W-2 -: ADDR_W];
          wdata_d = sr_nxt[DATA_W-1:0];
        end else begin
          wro_d   = sr_nxt[RD_BYTES*8-1];
          addr_d  = sr_nxt[ADDR_W-1:0];
          wdata_d = '0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      cmd_q   <= 1'b0;
      full_q  <= 1'b0;
      pulse_q <= 1'b0;
      wro_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      cmd_q   <= cmd_d;
      full_q  <= full_d;
      pulse_q <= pulse_d;
      wro_q   <= wro_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign full_o      = full_q;
  assign req_pulse_o = pulse_q;
  assign req_wr_o    = wro_q;
  assign req_addr_o  = addr_q;
  assign req_wdata_o = wdata_q;

  // R2: a request pulse never lasts two cycles
  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse_o |=> !req_pulse_o);

  // R10: a held request admits no further request until released
  a_r10_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !release_i) |=> !req_pulse_o);

endmodule

// File: rtl/bl_bus_port.sv
module bl_bus_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BUS_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              release_i,
  input  logic              bus_ack_i,
  input  logic [1:0]        bus_status_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic              done_o,
  output logic              ack_o,
  output logic [1:0]        status_o,
  output logic [DATA_W-1:0] rdata_o
);

  import bl_pkg::*;

  localparam int unsigned WC_W = $clog2(BUS_WAIT + 1);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(BUS_WAIT - 1);

  bp_state_e         state_q, state_d;
  logic [WC_W-1:0]   cnt_q, cnt_d;
  logic              ack_q, ack_d;
  logic [1:0]        sts_q, sts_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              active;

  assign bus_wr_o = start_i && wr_i;
  assign bus_rd_o = start_i && !wr_i;
  assign active   = start_i || (state_q == BP_WAIT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ack_d   = ack_q;
    sts_d   = sts_q;
    rdata_d = rdata_q;
    if (release_i) begin
      state_d = BP_IDLE;
      cnt_d   = '0;
    end else if (active) begin
      if (bus_ack_i) begin
        state_d = BP_DONE;
        cnt_d   = '0;
        ack_d   = 1'b1;
        sts_d   = bus_status_i;
        rdata_d = wr_i ? '0 : bus_rdata_i;
      end else if (cnt_q == WC_LAST) begin
        state_d = BP_DONE;
        cnt_d   = '0;
        ack_d   = 1'b0;
        sts_d   = 2'b00;
        rdata_d = '0;
      end else begin
        state_d = BP_WAIT;
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BP_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      sts_q   <= 2'b00;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      sts_q   <= sts_d;
      rdata_q <= rdata_d;
    end
  end

  assign done_o   = (state_q == BP_DONE);
  assign ack_o    = ack_q;
  assign status_o = sts_q;
  assign rdata_o  = rdata_q;

  // R2: a strobe only starts an access when none is outstanding
  a_r2_strobe_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o || bus_rd_o) |-> (state_q == BP_IDLE));

endmodule

// File: rtl/bl_resp_tx.sv
module bl_resp_tx #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TURN_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_i,
  input  logic              pend_i,
  input  logic              done_i,
  input  logic              wr_i,
  input  logic              ack_i,
  input  logic [1:0]        status_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              release_i,
  output logic              link_valid_o,
  output logic [7:0]        link_data_o,
  output logic              link_oe_o,
  output logic              finish_o
);

  import bl_pkg::*;

  localparam int unsigned RD_RESP = DATA_W / 8 + 1;
  localparam int unsigned SR_W    = RD_RESP * 8;
  localparam int unsigned RC_W    = $clog2(RD_RESP + 1);
  localparam int unsigned TC_W    = $clog2(TURN_WAIT + 2);

  logic            grant;
  logic [SR_W-1:0] sr_q, sr_d;
  logic [RC_W-1:0] rem_q, rem_d;
  logic            loaded_q, loaded_d;
  logic            send;

  generate
    if (TURN_WAIT == 0) begin : g_nowait
      assign grant = dir_i;
    end else begin : g_wait
      logic [TC_W-1:0] tc_q, tc_d;
      always_comb begin
        tc_d = tc_q;
        if (!dir_i) tc_d = '0;
        else if (tc_q != TC_W'(TURN_WAIT)) tc_d = tc_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tc_q <= '0;
        else        tc_q <= tc_d;
      end
      assign grant = dir_i && (tc_q == TC_W'(TURN_WAIT));

      // R7: drive never starts in the cycle direction first rises
      a_r7_oe_after_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_oe_o) |-> $past(dir_i));
    end
  endgenerate

  assign send = grant && loaded_q && (rem_q != '0);

  always_comb begin
    sr_d     = sr_q;
    rem_d    = rem_q;
    loaded_d = loaded_q;
    if (release_i) begin
      rem_d    = '0;
      loaded_d = 1'b0;
    end else if (done_i && !loaded_q) begin
      loaded_d = 1'b1;
      if (wr_i) begin
        sr_d  = {status_byte(ack_i, status_i), {(SR_W-8){1'b0}}};
        rem_d = RC_W'(1);
      end else begin
        sr_d  = {rdata_i, status_byte(ack_i, status_i)};
        rem_d = RC_W'(RD_RESP);
      end
    end else if (send) begin
      sr_d  = {sr_q[SR_W-9:0], 8'h00};
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      rem_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      sr_q     <= sr_d;
      rem_q    <= rem_d;
      loaded_q <= loaded_d;
    end
  end

  assign link_valid_o = send;
  assign link_data_o  = send ? sr_q[SR_W-1 -: 8] : 8'h00;
  assign link_oe_o    = grant && pend_i;
  assign finish_o     = send && (rem_q == RC_W'(1));

  // R8: valid is only presented while the lane is driven
  a_r8_valid_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid_o |-> link_oe_o);

endmodule

// File: rtl/bytelink_reg_slave.sv
module bytelink_reg_slave #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned TURN_WAIT = 2,
  parameter int unsigned BUS_WAIT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_dir_i,
  input  logic              link_valid_i,
  input  logic [7:0]        link_data_i,
  output logic              link_valid_o,
  output logic [7:0]        link_data_o,
  output logic              link_oe_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [1:0]        bus_status_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic              pend;
  logic              req_pulse;
  logic              req_wr;
  logic              bp_done;
  logic              bp_ack;
  logic [1:0]        bp_sts;
  logic [DATA_W-1:0] bp_rdata;
  logic              finish;
  logic              abandon;
  logic              release_t;
  logic              dir_seen_q, dir_seen_d;

  assign abandon   = pend && dir_seen_q && !link_dir_i;
  assign release_t = finish || abandon;

  always_comb begin
    dir_seen_d = dir_seen_q;
    if (release_t)             dir_seen_d = 1'b0;
    else if (pend && link_dir_i) dir_seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) dir_seen_q <= 1'b0;
    else             dir_seen_q <= dir_seen_d;
  end

  bl_req_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .dir_i       (link_dir_i),
    .valid_i     (link_valid_i),
    .data_i      (link_data_i),
    .release_i   (release_t),
    .full_o      (pend),
    .req_pulse_o (req_pulse),
    .req_wr_o    (req_wr),
    .req_addr_o  (bus_addr_o),
    .req_wdata_o (bus_wdata_o)
  );

  bl_bus_port #(.DATA_W(DATA_W), .BUS_WAIT(BUS_WAIT)) u_bus (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start_i      (req_pulse),
    .wr_i         (req_wr),
    .release_i    (release_t),
    .bus_ack_i    (bus_ack_i),
    .bus_status_i (bus_status_i),
    .bus_rdata_i  (bus_rdata_i),
    .bus_wr_o     (bus_wr_o),
    .bus_rd_o     (bus_rd_o),
    .done_o       (bp_done),
    .ack_o        (bp_ack),
    .status_o     (bp_sts),
    .rdata_o      (bp_rdata)
  );

  bl_resp_tx #(.DATA_W(DATA_W), .TURN_WAIT(TURN_WAIT)) u_tx (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .dir_i        (link_dir_i),
    .pend_i       (pend),
    .done_i       (bp_done),
    .wr_i         (req_wr),
    .ack_i        (bp_ack),
    .status_i     (bp_sts),
    .rdata_i      (bp_rdata),
    .release_i    (release_t),
    .link_valid_o (link_valid_o),
    .link_data_o  (link_data_o),
    .link_oe_o    (link_oe_o),
    .finish_o     (finish)
  );

  // R6: nothing is driven while the master owns the lane
  a_r6_quiet_without_dir: assert property (@(posedge clk) disable iff (!rst_core_n)
    !link_dir_i |-> (!link_oe_o && !link_valid_o));

  // R3: response bytes only follow a completed bus phase
  a_r3_send_after_bus: assert property (@(posedge clk) disable iff (!rst_core_n)
    link_valid_o |-> bp_done);

  // R9: withdrawal of direction frees the receiver on the next cycle
  a_r9_abandon_frees_rx: assert property (@(posedge clk) disable iff (!rst_core_n)
    abandon |=> !pend);

endmodule

// File: tb/sim_bytelink_reg_slave.sv
module sim_bytelink_reg_slave;

  localparam int ADDR_W    = 15;
  localparam int DATA_W    = 32;
  localparam int TURN_WAIT = 2;
  localparam int BUS_WAIT  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dir, vin;
  logic [7:0]        din;
  logic              ack;
  logic [1:0]        sts_in;
  logic [DATA_W-1:0] rd_in;
  logic              link_valid_o, link_oe_o, bus_wr_o, bus_rd_o;
  logic [7:0]        link_data_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bytelink_reg_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_WAIT(TURN_WAIT),
                       .BUS_WAIT(BUS_WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .link_dir_i(dir), .link_valid_i(vin), .link_data_i(din),
    .link_valid_o(link_valid_o), .link_data_o(link_data_o), .link_oe_o(link_oe_o),
    .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(ack), .bus_status_i(sts_in), .bus_rdata_i(rd_in)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // one complete transaction; delay<0 means the bus never answers
  task automatic run_txn(input bit wr, input logic [14:0] addr, input logic [31:0] wd,
                         input int delay, input logic [1:0] sts, input logic [31:0] rd,
                         input bit junk);
    logic [47:0] req;
    logic [39:0] resp;
    logic [7:0]  sb;
    bit          got;
    int          nreq, nresp;
    req   = {wr, addr, wd};
    nreq  = wr ? 6 : 2;
    nresp = wr ? 1 : 5;
    got   = (delay >= 0) && (delay < BUS_WAIT);
    sb    = {5'b00000, got, (got ? sts : 2'b00)};
    resp  = wr ? {sb, 32'h0} : {(got ? rd : 32'h0), sb};
    for (int i = 0; i < nreq; i++) begin
      tick();
      vin = 1'b1;
      din = req[47-8*i -: 8];
      #2;
      chk("R2 no strobe mid-request", {bus_wr_o, bus_rd_o}, 2'b00);
    end
    for (int j = 0; j < BUS_WAIT + 3; j++) begin
      tick();
      vin    = junk;
      din    = 8'hA5 ^ 8'(j);
      ack    = (j == delay);
      sts_in = sts;
      rd_in  = rd;
      #2;
      if (j == 0) begin
        chk("R1 R2 strobe kind", {bus_wr_o, bus_rd_o}, wr ? 2'b10 : 2'b01);
        chk("R1 address", bus_addr_o, addr);
        if (wr) chk("R1 write data", bus_wdata_o, wd);
      end else begin
        chk("R2 R10 strobe single", {bus_wr_o, bus_rd_o}, 2'b00);
        chk("R6 quiet while dir low", {link_oe_o, link_valid_o}, 2'b00);
      end
    end
    tick();
    vin = 1'b0;
    ack = 1'b0;
    dir = 1'b1;
    for (int k = 0; k < TURN_WAIT; k++) begin
      if (k > 0) tick();
      #2;
      chk("R7 turnaround gap", {link_oe_o, link_valid_o}, 2'b00);
    end
    for (int b = 0; b < nresp; b++) begin
      tick();
      #2;
      chk("R7 R8 drive", {link_oe_o, link_valid_o}, 2'b11);
      chk(got ? "R3 R5 response byte" : "R4 R5 response byte", link_data_o, resp[39-8*b -: 8]);
    end
    tick();
    #2;
    chk("R8 release after last byte", {link_oe_o, link_valid_o}, 2'b00);
    tick();
    dir = 1'b0;
  endtask

  task automatic abandon_txn(input int keep);
    logic [39:0] resp;
    resp = {32'hCAFEF00D, 8'b00000101};
    tick(); vin = 1'b1; din = 8'h0A;
    tick(); din = 8'hBC;
    tick(); vin = 1'b0; ack = 1'b1; sts_in = 2'b01; rd_in = 32'hCAFEF00D;
    tick(); ack = 1'b0;
    tick();
    tick(); dir = 1'b1;
    for (int k = 1; k < TURN_WAIT; k++) tick();
    for (int b = 0; b < keep; b++) begin
      tick();
      #2;
      chk("R9 partial byte", link_data_o, resp[39-8*b -: 8]);
    end
    tick();
    dir = 1'b0;
    #2;
    chk("R6 R9 stop at once", {link_oe_o, link_valid_o}, 2'b00);
    tick();
    #2;
    chk("R9 stays quiet", {link_oe_o, link_valid_o, bus_wr_o, bus_rd_o}, 4'b0000);
  endtask

  task automatic dir_junk();
    tick(); dir = 1'b1; vin = 1'b1; din = 8'h00;
    tick(); din = 8'h55;
    tick(); vin = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk("R10 ignored while dir high", {bus_wr_o, bus_rd_o, link_oe_o}, 3'b000);
      tick();
    end
    dir = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; dir = 1'b0; vin = 1'b0; din = 8'h00;
    ack = 1'b0; sts_in = 2'b00; rd_in = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 outputs in reset", {link_oe_o, link_valid_o, bus_wr_o, bus_rd_o}, 4'b0000);
    @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();
    #2;
    chk("R11 outputs after reset", {link_oe_o, link_valid_o, bus_wr_o, bus_rd_o}, 4'b0000);

    for (int op = 0; op < 2; op++) begin
      for (int d = -1; d <= BUS_WAIT; d++) begin
        run_txn(op[0], 15'(4919 * (d + 2) + op), 32'h9E3779B9 * 32'(d + 3 + op),
                d, 2'(d + op), 32'h01234567 ^ 32'(d * 4099), (d == 1));
      end
    end
    run_txn(1'b0, 15'h0000, 32'h0, 0, 2'b11, 32'hFFFFFFFF, 1'b0);
    run_txn(1'b1, 15'h7FFF, 32'hFFFFFFFF, 1, 2'b10, 32'h0, 1'b1);

    abandon_txn(0);
    run_txn(1'b0, 15'h2468, 32'h0, 2, 2'b00, 32'h80000001, 1'b0);
    abandon_txn(2);
    run_txn(1'b1, 15'h1111, 32'hA5A55A5A, 0, 2'b01, 32'h0, 1'b0);
    abandon_txn(4);
    run_txn(1'b0, 15'h4000, 32'h0, 3, 2'b10, 32'h76543210, 1'b0);

    dir_junk();
    run_txn(1'b0, 15'h0055, 32'h0, 0, 2'b00, 32'h00C0FFEE, 1'b0);

    summary();
    $finish;
  end

endmodule